// File: doc/BRIEF.md
# Serial Flash Command Slave

This block is the slave end of a small serial NOR flash as seen on a four-wire SPI bus (mode 0): an active-low select, a serial clock, a data input and a data output with a separate output enable. The bus lines are oversampled by the system clock, so the serial clock must stay at least six system clocks high and six low. The block collects an opcode byte and, where the opcode calls for one, a 24-bit address, then either streams bytes out or carries out a state-changing command when select goes high.

The storage is an internal byte array with one synchronous read port and one write port. The array comes out of reset fully erased. Programming clears bits only: each new byte is ANDed into the old one. A status register holds a busy flag, a write-enable latch and three protect bits. The protect bits shield a region of low sectors against program and erase. While an internal program, erase or status-write cycle runs, only the status read is accepted. Each such cycle lasts a fixed number of clocks.

Opcodes (hex): 01 write status, 02 program, 03 read, 04 write disable, 05 read status, 06 write enable, AB read identifier, C7 bulk erase, D8 sector erase.

Top module: `flash_cmd_slave`

## Requirements
- R1: Input bits are captured on rising serial-clock edges and output bits change only on falling edges, most significant bit first. The output enable is high only while a byte is being shifted out, and is low whenever select is high.
- R2: After reset, no command takes effect until select has been seen high and then falling. Clock edges while select stays low from reset are ignored.
- R3: Opcode 03 followed by a 24-bit address streams bytes from consecutive addresses. Only the low AW address bits are used, so higher bits have no effect.
- R4: Opcode 05 shifts out the status byte, and repeats it for each further byte. The layout is bit 0 busy, bit 1 write-enable latch, bits 4:2 protect level, and bits 7:5 zero.
- R5: Opcode 06 sets the write-enable latch and opcode 04 clears it. Each acts when select rises after exactly eight bits.
- R6: Opcode 02 followed by an address and data bytes ANDs each byte into consecutive locations, but only if the latch was set when the address was complete. If at least one byte was written, raising select starts a busy cycle of BUSY_CYC clocks.
- R7: With the latch set, opcode D8 plus an address sets every byte of that sector to FF, and opcode C7 sets the whole array to FF. The busy time is one clock per erased byte.
- R8: After reset every array byte reads FF.
- R9: Opcode AB followed by three dummy bytes shifts out the ID_CODE byte.
- R10: With the latch set, opcode 01 followed by one data byte loads data bits 4:2 into the protect level and starts a BUSY_CYC busy cycle. Without the latch, the command does nothing.
- R11: A protect level p other than 0 shields the lowest NSECT - (NSECT >> p) sectors. A sector erase of a shielded sector, a program byte aimed at a shielded sector, and a bulk erase at any nonzero level are refused. A refused command leaves the array and the status unchanged.
- R12: While busy, every opcode except 05 is ignored: no output and no change to the array or the status.
- R13: The write-enable latch clears in the same clock in which a busy cycle ends.
- R14: Raising select before a command is complete aborts it with no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| spi_cs_n | input | 1 | Active-low select |
| spi_sck | input | 1 | Serial clock (mode 0) |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Output enable for spi_miso; low means high impedance |

## Verification
On every clock, the assertions check that the output is released while select is high and that the output shift register holds still between falling edges. They also check that a program write never happens without the latch, that no write of any kind lands in a shielded sector, that the latch is clear when a busy cycle ends, and that an opcode arriving while busy leads only to the status read or to the ignore state. Whether streamed bytes match the array contents, whether the AND programming, the erase fill and the protect boundaries are right, and whether a refused or aborted command leaves the status byte exactly as it was can only be shown by the bench. The bench does this by comparing whole transactions against its own array and status model.

// File: rtl/flash_pkg.sv
package flash_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_OUT, ST_WDATA, ST_SRIN, ST_HOLD, ST_SINK
    } st_e;

    typedef enum logic [3:0] {
        C_NONE, C_READ, C_RDSR, C_RDID, C_PROG, C_SERASE, C_BERASE, C_WRSR, C_WREN, C_WRDI
    } cmd_e;

    localparam logic [7:0] OP_WRSR   = 8'h01;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_WRDI   = 8'h04;
    localparam logic [7:0] OP_RDSR   = 8'h05;
    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_RDID   = 8'hAB;
    localparam logic [7:0] OP_BERASE = 8'hC7;
    localparam logic [7:0] OP_SERASE = 8'hD8;

endpackage

// File: rtl/flash_array.sv
module flash_array #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          we,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells_q [DEPTH];

    // erased state (all ones) out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells_q[i] <= '1;
            rd_data <= '1;
        end else begin
            rd_data <= cells_q[rd_addr];
            if (we) cells_q[wr_addr] <= wr_data;
        end
    end
endmodule

// File: rtl/flash_protect.sv
module flash_protect #(
    parameter int SW = 3
) (
    input  logic [2:0]    level,
    input  logic [SW-1:0] sector,
    output logic          hit
);
    localparam logic [SW:0] NSECT = (SW+1)'(1 << SW);

    logic [SW:0] limit;

    // shielded sectors: the lowest NSECT - NSECT/2^level
    always_comb begin
        limit = NSECT - (NSECT >> level);
        hit   = ({1'b0, sector} < limit);
    end
endmodule

// File: rtl/flash_cmd_slave.sv
module flash_cmd_slave
    import flash_pkg::*;
#(
    parameter int         AW       = 8,
    parameter int         SW       = 3,
    parameter int         BUSY_CYC = 16,
    parameter logic [7:0] ID_CODE  = 8'h5A
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe
);
    localparam int OFF_W      = AW - SW;
    localparam int SECT_BYTES = 1 << OFF_W;
    localparam int ARR_BYTES  = 1 << AW;
    localparam int BMAX       = (ARR_BYTES > BUSY_CYC) ? ARR_BYTES : BUSY_CYC;
    localparam int CW         = $clog2(BMAX + 1);

    typedef struct packed {
        logic          cs;
        logic          cs_p;
        logic          sck;
        logic          sck_p;
        logic          mosi;
        st_e           st;
        cmd_e          cmd;
        logic [4:0]    cnt;
        logic [6:0]    sin;
        logic [AW-1:0] addr;
        logic [7:0]    sout;
        logic [2:0]    obit;
        logic          pg_ok;
        logic          pg_wr;
        logic          wel;
        logic [2:0]    bp;
        logic [CW-1:0] busy;
        logic          erasing;
        logic [AW-1:0] eptr;
    } state_t;

    state_t q, d;

    logic          rise, fall, cs_fall, cs_rise, wip;
    logic [7:0]    bit_in, rd_data, mem_wdata;
    logic          mem_we, addr_hit, wr_hit;
    logic [AW-1:0] mem_waddr;

    assign rise    = q.sck & ~q.sck_p;
    assign fall    = ~q.sck & q.sck_p;
    assign cs_fall = q.cs_p & ~q.cs;
    assign cs_rise = q.cs & ~q.cs_p;
    assign wip     = (q.busy != '0);
    assign bit_in  = {q.sin, q.mosi};

    flash_array #(.AW(AW), .DW(8)) u_array (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(q.addr), .rd_data(rd_data),
        .we(mem_we), .wr_addr(mem_waddr), .wr_data(mem_wdata)
    );

    flash_protect #(.SW(SW)) u_prot_cmd (
        .level(q.bp), .sector(q.addr[AW-1:OFF_W]), .hit(addr_hit)
    );

    flash_protect #(.SW(SW)) u_prot_wr (
        .level(q.bp), .sector(mem_waddr[AW-1:OFF_W]), .hit(wr_hit)
    );

    always_comb begin
        d         = q;
        mem_we    = 1'b0;
        mem_waddr = '0;
        mem_wdata = '0;
        d.cs      = spi_cs_n;
        d.cs_p    = q.cs;
        d.sck     = spi_sck;
        d.sck_p   = q.sck;
        d.mosi    = spi_mosi;

        // self-timed cycle: erase walks one byte per clock
        if (wip) begin
            d.busy = q.busy - 1'b1;
            if (q.erasing) begin
                mem_we    = 1'b1;
                mem_waddr = q.eptr;
                mem_wdata = 8'hFF;
                d.eptr    = q.eptr + 1'b1;
            end
            if (q.busy == CW'(1)) begin
                d.wel     = 1'b0;
                d.erasing = 1'b0;
            end
        end

        if (cs_fall) begin
            d.st  = ST_OPC;
            d.cnt = '0;
        end else if (cs_rise) begin
            case (q.cmd)
                C_WREN: if (q.st == ST_HOLD) d.wel = 1'b1;
                C_WRDI: if (q.st == ST_HOLD) d.wel = 1'b0;
                C_WRSR: if (q.st == ST_HOLD && q.wel) begin
                    d.bp   = q.sin[4:2];
                    d.busy = CW'(BUSY_CYC);
                end
                C_SERASE: if (q.st == ST_HOLD && q.wel && !addr_hit) begin
                    d.busy    = CW'(SECT_BYTES);
                    d.erasing = 1'b1;
                    d.eptr    = {q.addr[AW-1:OFF_W], OFF_W'(0)};
                end
                C_BERASE: if (q.st == ST_HOLD && q.wel && q.bp == 3'd0) begin
                    d.busy    = CW'(ARR_BYTES);
                    d.erasing = 1'b1;
                    d.eptr    = '0;
                end
                C_PROG: if (q.st == ST_WDATA && q.pg_wr) d.busy = CW'(BUSY_CYC);
                default: ;
            endcase
            d.st = ST_IDLE;
        end else if (rise) begin
            case (q.st)
                ST_OPC: begin
                    d.sin = bit_in[6:0];
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == 5'd7) begin
                        d.cnt  = '0;
                        d.obit = '0;
                        d.st   = ST_SINK;
                        d.cmd  = C_NONE;
                        if (!wip || bit_in == OP_RDSR) begin
                            case (bit_in)
                                OP_READ:   begin d.cmd = C_READ;   d.st = ST_ADDR; end
                                OP_RDSR:   begin d.cmd = C_RDSR;   d.st = ST_OUT;  end
                                OP_RDID:   begin d.cmd = C_RDID;   d.st = ST_ADDR; end
                                OP_PROG:   begin d.cmd = C_PROG;   d.st = ST_ADDR; end
                                OP_SERASE: begin d.cmd = C_SERASE; d.st = ST_ADDR; end
                                OP_BERASE: begin d.cmd = C_BERASE; d.st = ST_HOLD; end
                                OP_WREN:   begin d.cmd = C_WREN;   d.st = ST_HOLD; end
                                OP_WRDI:   begin d.cmd = C_WRDI;   d.st = ST_HOLD; end
                                OP_WRSR:   begin d.cmd = C_WRSR;   d.st = ST_SRIN; end
                                default:   ;
                            endcase
                        end
                    end
                end
                ST_ADDR: begin
                    d.addr = {q.addr[AW-2:0], q.mosi};
                    d.cnt  = q.cnt + 1'b1;
                    if (q.cnt == 5'd23) begin
                        d.cnt   = '0;
                        d.pg_ok = q.wel;
                        d.pg_wr = 1'b0;
                        case (q.cmd)
                            C_PROG:   d.st = ST_WDATA;
                            C_SERASE: d.st = ST_HOLD;
                            default:  d.st = ST_OUT;
                        endcase
                    end
                end
                ST_WDATA: begin
                    d.sin = bit_in[6:0];
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == 5'd7) begin
                        d.cnt = '0;
                        if (q.pg_ok && !addr_hit) begin
                            mem_we    = 1'b1;
                            mem_waddr = q.addr;
                            mem_wdata = bit_in & rd_data;
                            d.pg_wr   = 1'b1;
                        end
                        d.addr = q.addr + 1'b1;
                    end
                end
                ST_SRIN: begin
                    d.sin = bit_in[6:0];
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == 5'd7) d.st = ST_HOLD;
                end
                ST_HOLD: d.st = ST_SINK;
                default: ;
            endcase
        end else if (fall && q.st == ST_OUT) begin
            d.obit = q.obit + 1'b1;
            if (q.obit == 3'd0) begin
                case (q.cmd)
                    C_READ: begin
                        d.sout = rd_data;
                        d.addr = q.addr + 1'b1;
                    end
                    C_RDSR:  d.sout = {3'b000, q.bp, q.wel, wip};
                    default: d.sout = ID_CODE;
                endcase
            end else begin
                d.sout = {q.sout[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign spi_miso    = q.sout[7];
    assign spi_miso_oe = (q.st == ST_OUT);

    p_oe_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        q.cs |=> !spi_miso_oe);

    p_out_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_OUT && !fall) |=> $stable(spi_miso));

    p_prog_needs_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !q.erasing) |-> q.wel);

    p_no_shielded_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !wr_hit);

    p_wel_cleared_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !q.wel);

    p_busy_ignores_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_OPC && rise && !cs_rise && !cs_fall && q.cnt == 5'd7 && wip)
        |=> (q.st == ST_SINK || (q.st == ST_OUT && q.cmd == C_RDSR)));

endmodule

// File: tb/flash_cmd_slave_test.sv
module flash_cmd_slave_test;
    localparam int H = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b0, sck = 1'b0, mosi = 1'b0;
    logic miso, oe;

    int checks = 0, errors = 0, oe_hits = 0, hi_cnt = 0;
    bit done = 1'b0;

    logic [7:0] ref_mem [256];
    logic       ref_wel = 1'b0;
    logic [2:0] ref_bp  = 3'd0;

    always #2 clk = ~clk;

    flash_cmd_slave #(.AW(8), .SW(3), .BUSY_CYC(3000), .ID_CODE(8'h5A)) uut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
        .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // per-clock compare: released output while deselected (R1)
    always @(negedge clk) begin
        if (cs_n) hi_cnt++; else hi_cnt = 0;
        if (rst_n && hi_cnt >= 3) begin
            checks++;
            if (oe !== 1'b0) begin
                errors++;
                $display("FAIL R1 oe while deselected: actual %b expected 0", oe);
            end
        end
    end

    initial begin
        repeat (190000) @(negedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i >= 8 - nbits; i--) begin
            mosi = tx[i];
            tick(H);
            rx[i] = miso;
            if (oe) oe_hits++;
            sck = 1'b1;
            tick(H);
            sck = 1'b0;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        tick(4);
    endtask

    task automatic desel();
        tick(H);
        cs_n = 1'b1;
        tick(8);
    endtask

    task automatic send_op_addr(input logic [7:0] op, input logic [23:0] a);
        logic [7:0] r;
        xfer(op, 8, r);
        xfer(a[23:16], 8, r);
        xfer(a[15:8], 8, r);
        xfer(a[7:0], 8, r);
    endtask

    function automatic bit shielded(input logic [2:0] lvl, input int a);
        int s = (a >> 5) & 7;
        return (lvl != 0) && (s < 8 - (8 >> lvl));
    endfunction

    task automatic rdsr(output logic [7:0] v);
        logic [7:0] r;
        sel();
        xfer(8'h05, 8, r);
        xfer(8'h00, 8, v);
        desel();
    endtask

    task automatic chk_status(input string tag);
        logic [7:0] v;
        rdsr(v);
        chk(tag, {24'h0, v}, {24'h0, 3'b000, ref_bp, ref_wel, 1'b0});
    endtask

    task automatic wait_ready();
        logic [7:0] v;
        for (int k = 0; k < 300; k++) begin
            rdsr(v);
            if (!v[0]) break;
        end
    endtask

    task automatic simple_op(input logic [7:0] op);
        logic [7:0] r;
        sel();
        xfer(op, 8, r);
        desel();
        if (op == 8'h06) ref_wel = 1'b1;
        if (op == 8'h04) ref_wel = 1'b0;
    endtask

    task automatic prog(input int a, input logic [7:0] data [$]);
        logic [7:0] r;
        bit wrote = 1'b0;
        int p = a & 255;
        sel();
        send_op_addr(8'h02, 24'(a));
        foreach (data[k]) begin
            xfer(data[k], 8, r);
            if (ref_wel && !shielded(ref_bp, p)) begin
                ref_mem[p] = ref_mem[p] & data[k];
                wrote = 1'b1;
            end
            p = (p + 1) & 255;
        end
        desel();
        if (wrote) ref_wel = 1'b0;
    endtask

    task automatic read_chk(input string tag, input int a, input int n);
        logic [7:0] r;
        sel();
        send_op_addr(8'h03, 24'(a));
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, 8, r);
            chk(tag, {24'h0, r}, {24'h0, ref_mem[(a + k) & 255]});
        end
        desel();
    endtask

    task automatic sector_erase(input int a);
        sel();
        send_op_addr(8'hD8, 24'(a));
        desel();
        if (ref_wel && !shielded(ref_bp, a & 255)) begin
            for (int k = 0; k < 32; k++) ref_mem[(a & 8'hE0) + k] = 8'hFF;
            ref_wel = 1'b0;
        end
    endtask

    task automatic bulk_erase();
        simple_op(8'hC7);
        if (ref_wel && ref_bp == 0) begin
            for (int k = 0; k < 256; k++) ref_mem[k] = 8'hFF;
            ref_wel = 1'b0;
        end
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] r;
        sel();
        xfer(8'h01, 8, r);
        xfer(v, 8, r);
        desel();
        if (ref_wel) begin
            ref_bp  = v[4:2];
            ref_wel = 1'b0;
        end
    endtask

    initial begin
        logic [7:0] r;
        logic [7:0] v;
        for (int k = 0; k < 256; k++) ref_mem[k] = 8'hFF;
        tick(5);
        chk("R1 oe low in reset", {31'h0, oe}, 32'h0);
        rst_n = 1'b1;
        tick(4);

        // R2: select low since reset, a write-enable must be ignored
        xfer(8'h06, 8, r);
        tick(H);
        cs_n = 1'b1;
        tick(8);
        chk_status("R2 no action before select falls");

        chk_status("R4 status after reset");
        read_chk("R8 erased array", 'h10, 4);

        // R6: program without latch refused
        prog('h20, '{8'h12});
        chk_status("R6 refused program status");
        read_chk("R6 refused program data", 'h20, 1);

        simple_op(8'h06);
        chk_status("R5 write enable");
        simple_op(8'h04);
        chk_status("R5 write disable");

        // R14: abort write enable after five bits
        sel();
        xfer(8'h06, 5, r);
        desel();
        chk_status("R14 aborted write enable");

        // program, then probe while busy
        simple_op(8'h06);
        prog('h20, '{8'hA5, 8'h3C});
        rdsr(v);
        chk("R6 busy and latch during program", {24'h0, v}, 32'h03);
        oe_hits = 0;
        sel();
        send_op_addr(8'h03, 24'h000020);
        xfer(8'h00, 8, r);
        desel();
        chk("R12 read ignored while busy", oe_hits, 0);
        sel();
        send_op_addr(8'hD8, 24'h000020);
        desel();
        wait_ready();
        chk_status("R13 latch cleared after program");
        read_chk("R12 erase while busy ignored, R3 stream", 'h1F, 3);

        simple_op(8'h06);
        prog('h20, '{8'h0F});
        wait_ready();
        read_chk("R6 program ANDs bits", 'h20, 1);
        chk({"R6 AND value"}, {24'h0, ref_mem['h20]}, 32'h05);

        read_chk("R3 high address bits ignored", 'hAB0021, 1);

        sel();
        send_op_addr(8'hAB, 24'h000000);
        xfer(8'h00, 8, r);
        desel();
        chk("R9 identifier", {24'h0, r}, 32'h5A);

        simple_op(8'h06);
        prog('hA0, '{8'h00, 8'h11});
        wait_ready();

        // R10: set protect level 1 (lower half)
        simple_op(8'h06);
        wrsr(8'h04);
        wait_ready();
        chk_status("R10 protect level loaded");

        simple_op(8'h06);
        sector_erase('h25);
        chk_status("R11 shielded sector erase refused status");
        read_chk("R11 shielded sector data kept", 'h20, 1);
        bulk_erase();
        chk_status("R11 bulk erase refused status");
        prog('h30, '{8'h00});
        chk_status("R11 shielded program status");
        read_chk("R11 shielded program data", 'h30, 1);

        sector_erase('hA3);
        wait_ready();
        read_chk("R7 sector erased", 'hA0, 2);
        read_chk("R7 other sector kept", 'h20, 1);
        chk_status("R13 latch cleared after erase");

        simple_op(8'h06);
        wrsr(8'h00);
        wait_ready();
        simple_op(8'h06);
        bulk_erase();
        wait_ready();
        read_chk("R7 bulk erased", 'h20, 2);
        chk_status("R7 status after bulk erase");

        // boundary at level 2: sectors 0..5 shielded
        simple_op(8'h06);
        wrsr(8'h08);
        wait_ready();
        simple_op(8'h06);
        prog('hBF, '{8'h00, 8'h00});
        wait_ready();
        read_chk("R11 level 2 boundary", 'hBF, 2);
        chk({"R11 first open byte"}, {24'h0, ref_mem['hC0]}, 32'h00);

        wrsr(8'h1C);
        chk_status("R10 status write without latch");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule